// File: doc/BRIEF.md
# Phase-Domain Sigma-Delta Sensor Controller

This block is the digital back end of a temperature sensor that measures the phase lag of an on-chip thermal filter with a phase-domain sigma-delta loop. It runs from one crystal clock and produces every timing signal the analog side needs. These are a square-wave heater drive, two reference square waves at the drive frequency that sit symmetrically before and after a nominal phase, a slow chop signal that inverts the whole front-end, and a sample strobe.

Once per sample period the block latches the single-bit comparator result. That bit picks which reference square wave drives the demodulator for the following sample period: a one picks the later reference and a zero picks the earlier one. The bit is corrected for the chop state and added into a counter that runs over a window of whole chop periods, which forms a first-order sinc decimator whose notches fall on the chop ripple. At the end of each window the count appears on the output word with a one-cycle valid pulse.

Top module: `pdsd_controller`

## Requirements
- R1: The drive square wave (heater output XOR chop) has a period of DRIVE_PERIOD clocks. It is high for the first DRIVE_PERIOD/2 clocks of each period, counted from drive count 0.
- R2: The early reference rises PHASE_NOM-PHASE_OFF clocks after each drive rising edge and the late reference rises PHASE_NOM+PHASE_OFF clocks after it. Both have 50% duty.
- R3: The sample strobe is a one-cycle pulse every DRIVE_PERIOD*DRIVES_PER_SAMPLE clocks, in the last clock of a drive period.
- R4: The comparator input is latched on the strobe clock. From the next clock until the next strobe, the demodulator output equals the late reference if the latched bit is 1 and the early reference if it is 0. The selection changes only at drive-period boundaries.
- R5: The chop output starts at 0 and toggles after every CHOP_HALF samples, only at sample boundaries. The heater output is the drive square wave inverted while chop is 1.
- R6: Each latched bit is XORed with the chop state of its own sample period before it is counted.
- R7: A window is 2*CHOP_HALF*WINDOW_CHOPS samples. In the clock after the window's final strobe, the output word holds the window's count and the valid flag is high for exactly that one clock. The next window counts from zero.
- R8: The full-scale count, where every corrected bit is 1, equals the window length and is presented without wrap. The accumulator never exceeds the window length.
- R9: While the synchronous active-low reset is held, the valid flag and output word are 0, chop is 0, and the demodulator follows the early reference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal-derived system clock |
| rst_n | input | 1 | Synchronous active-low reset |
| comp_in | input | 1 | Single-bit comparator result |
| heater_drv | output | 1 | Heater drive square wave, inverted during chop |
| ref_early | output | 1 | Reference square wave leading the nominal phase |
| ref_late | output | 1 | Reference square wave trailing the nominal phase |
| demod_ref | output | 1 | Reference chosen by the last latched bit |
| chop | output | 1 | Low-frequency front-end inversion |
| sample_strb | output | 1 | One-cycle pulse marking the end of a sample period |
| dec_word | output | CNT_W | Decimated count of the last window |
| dec_valid | output | 1 | One-cycle pulse when dec_word is updated |

## Verification
On every clock, the embedded assertions check that the chop state and the reference selection change only at the boundaries where they are allowed. They also check that the valid flag never lasts more than one clock and that the accumulator stays within the window length. The bench's scenarios are the only source of evidence for the count values per window: all ones, bits equal to chop, bits opposite to chop, and a sparse pattern. The scenarios also measure the phase offsets of the two references, the drive and sample periods, and the demodulator following each latched bit.

// File: rtl/pdsd_pkg.sv
// Shared definitions for the phase-domain sigma-delta controller.
// Assumes: reference indices are 0 (early) and 1 (late).
package pdsd_pkg;
    typedef enum logic {REF_EARLY = 1'b0, REF_LATE = 1'b1} ref_sel_e;

    // Drive count at which a reference of the given index goes high.
    function automatic int ref_start(input int nom, input int off, input int idx);
        return (idx == 0) ? (nom - off) : (nom + off);
    endfunction
endpackage

// File: rtl/pdsd_timebase.sv
// Counter chain: drive period, sample period, chop half period, window.
// Assumes: all counts >= 1; every boundary is a drive-period boundary.
module pdsd_timebase #(
    parameter int DRIVE_PERIOD     = 188,
    parameter int DRIVES_PER_SAMPLE = 32,
    parameter int CHOP_HALF        = 64,
    parameter int WINDOW_CHOPS     = 64
) (
    input  logic                            clk,
    input  logic                            rst_n,
    output logic [$clog2(DRIVE_PERIOD)-1:0] drv_cnt,
    output logic                            drv_wrap,
    output logic                            sample_tick,
    output logic                            chop_q,
    output logic                            win_end
);
    localparam int DRV_W  = $clog2(DRIVE_PERIOD);
    localparam int SMP_W  = $clog2(DRIVES_PER_SAMPLE + 1);
    localparam int HALF_W = $clog2(CHOP_HALF + 1);
    localparam int HALVES = 2 * WINDOW_CHOPS;
    localparam int WIN_W  = $clog2(HALVES + 1);

    logic [SMP_W-1:0]  smp_cnt;
    logic [HALF_W-1:0] half_cnt;
    logic [WIN_W-1:0]  win_cnt;
    logic              half_end;

    assign drv_wrap    = (drv_cnt == DRV_W'(DRIVE_PERIOD - 1));
    assign sample_tick = drv_wrap && (smp_cnt == SMP_W'(DRIVES_PER_SAMPLE - 1));
    assign half_end    = sample_tick && (half_cnt == HALF_W'(CHOP_HALF - 1));
    assign win_end     = half_end && (win_cnt == WIN_W'(HALVES - 1));

    // Drive-period counter, free running.
    always_ff @(posedge clk) begin
        if (!rst_n)        drv_cnt <= '0;
        else if (drv_wrap) drv_cnt <= '0;
        else               drv_cnt <= drv_cnt + 1'b1;
    end

    // Drive periods within a sample period.
    always_ff @(posedge clk) begin
        if (!rst_n)           smp_cnt <= '0;
        else if (sample_tick) smp_cnt <= '0;
        else if (drv_wrap)    smp_cnt <= smp_cnt + 1'b1;
    end

    // Samples within a chop half period, and the chop state itself.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half_cnt <= '0;
            chop_q   <= 1'b0;
        end else if (half_end) begin
            half_cnt <= '0;
            chop_q   <= ~chop_q;
        end else if (sample_tick) begin
            half_cnt <= half_cnt + 1'b1;
        end
    end

    // Chop half periods within one decimation window.
    always_ff @(posedge clk) begin
        if (!rst_n)        win_cnt <= '0;
        else if (win_end)  win_cnt <= '0;
        else if (half_end) win_cnt <= win_cnt + 1'b1;
    end

    // R5
    chop_at_sample_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(chop_q) |-> $past(sample_tick));
endmodule

// File: rtl/pdsd_phase_gen.sv
// Drive square wave, two phase-shifted references and the demodulator
// selector. The selector loads the comparator bit only on the strobe,
// which always falls on a drive-period boundary.
// Assumes: PHASE_NOM >= PHASE_OFF and PHASE_NOM + PHASE_OFF < DRIVE_PERIOD.
module pdsd_phase_gen
    import pdsd_pkg::*;
#(
    parameter int DRIVE_PERIOD = 188,
    parameter int PHASE_NOM    = 47,
    parameter int PHASE_OFF    = 47
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [$clog2(DRIVE_PERIOD)-1:0] drv_cnt,
    input  logic                            drv_wrap,
    input  logic                            sample_tick,
    input  logic                            comp_in,
    output logic                            drive_sq,
    output logic [1:0]                      refs,
    output logic                            demod
);
    localparam int DRV_W = $clog2(DRIVE_PERIOD);
    localparam int HALF  = DRIVE_PERIOD / 2;

    ref_sel_e sel_q;

    assign drive_sq = (drv_cnt < DRV_W'(HALF));

    // One reference per index; each is the drive wave delayed by its start count.
    for (genvar g = 0; g < 2; g++) begin : g_ref
        localparam int START = ref_start(PHASE_NOM, PHASE_OFF, g);
        logic [DRV_W:0] idx_raw;
        logic [DRV_W:0] idx;
        always_comb begin
            idx_raw = {1'b0, drv_cnt} + (DRV_W+1)'(DRIVE_PERIOD - START);
            idx     = (idx_raw >= (DRV_W+1)'(DRIVE_PERIOD))
                      ? idx_raw - (DRV_W+1)'(DRIVE_PERIOD) : idx_raw;
            refs[g] = (idx < (DRV_W+1)'(HALF));
        end
    end

    // Selector register: loads the comparator bit at each sample strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)           sel_q <= REF_EARLY;
        else if (sample_tick) sel_q <= comp_in ? REF_LATE : REF_EARLY;
    end

    assign demod = (sel_q == REF_LATE) ? refs[1] : refs[0];

    // R4
    sel_at_drive_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sel_q) |-> $past(drv_wrap));
endmodule

// File: rtl/pdsd_decimator.sv
// First-order sinc decimator: counts chop-corrected bits over a window
// and publishes the total with a one-cycle valid pulse.
// Assumes: CNT_W can hold WIN_LEN; win_end only coincides with sample_tick.
module pdsd_decimator #(
    parameter int CNT_W   = 14,
    parameter int WIN_LEN = 8192
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample_tick,
    input  logic             win_end,
    input  logic             chop_q,
    input  logic             comp_in,
    output logic [CNT_W-1:0] dec_word,
    output logic             dec_valid
);
    logic [CNT_W-1:0] acc_q;
    logic [CNT_W-1:0] acc_next;
    logic             bit_corr;

    assign bit_corr = comp_in ^ chop_q;
    assign acc_next = acc_q + CNT_W'(bit_corr);

    // Accumulate per sample; publish and clear at the window end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q     <= '0;
            dec_word  <= '0;
            dec_valid <= 1'b0;
        end else begin
            dec_valid <= 1'b0;
            if (sample_tick) begin
                if (win_end) begin
                    dec_word  <= acc_next;
                    dec_valid <= 1'b1;
                    acc_q     <= '0;
                end else begin
                    acc_q <= acc_next;
                end
            end
        end
    end

    // R7
    valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |=> !dec_valid);

    // R8
    acc_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_q <= CNT_W'(WIN_LEN));
endmodule

// File: rtl/pdsd_controller.sv
// Top of the phase-domain sigma-delta controller: timebase, phase
// generator and decimator. The heater drive is inverted while chop is high.
// Assumes: the comparator input is already synchronous to clk.
module pdsd_controller #(
    parameter int DRIVE_PERIOD      = 188,
    parameter int DRIVES_PER_SAMPLE = 32,
    parameter int PHASE_NOM         = 47,
    parameter int PHASE_OFF         = 47,
    parameter int CHOP_HALF         = 64,
    parameter int WINDOW_CHOPS      = 64,
    parameter int CNT_W             = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             comp_in,
    output logic             heater_drv,
    output logic             ref_early,
    output logic             ref_late,
    output logic             demod_ref,
    output logic             chop,
    output logic             sample_strb,
    output logic [CNT_W-1:0] dec_word,
    output logic             dec_valid
);
    localparam int DRV_W   = $clog2(DRIVE_PERIOD);
    localparam int WIN_LEN = 2 * CHOP_HALF * WINDOW_CHOPS;

    logic [DRV_W-1:0] drv_cnt;
    logic             drv_wrap;
    logic             sample_tick;
    logic             chop_q;
    logic             win_end;
    logic             drive_sq;
    logic [1:0]       refs;

    pdsd_timebase #(
        .DRIVE_PERIOD(DRIVE_PERIOD), .DRIVES_PER_SAMPLE(DRIVES_PER_SAMPLE),
        .CHOP_HALF(CHOP_HALF), .WINDOW_CHOPS(WINDOW_CHOPS)
    ) u_tb (
        .clk(clk), .rst_n(rst_n), .drv_cnt(drv_cnt), .drv_wrap(drv_wrap),
        .sample_tick(sample_tick), .chop_q(chop_q), .win_end(win_end)
    );

    pdsd_phase_gen #(
        .DRIVE_PERIOD(DRIVE_PERIOD), .PHASE_NOM(PHASE_NOM), .PHASE_OFF(PHASE_OFF)
    ) u_ph (
        .clk(clk), .rst_n(rst_n), .drv_cnt(drv_cnt), .drv_wrap(drv_wrap),
        .sample_tick(sample_tick), .comp_in(comp_in), .drive_sq(drive_sq),
        .refs(refs), .demod(demod_ref)
    );

    pdsd_decimator #(.CNT_W(CNT_W), .WIN_LEN(WIN_LEN)) u_dec (
        .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick), .win_end(win_end),
        .chop_q(chop_q), .comp_in(comp_in), .dec_word(dec_word), .dec_valid(dec_valid)
    );

    assign heater_drv  = drive_sq ^ chop_q;
    assign ref_early   = refs[0];
    assign ref_late    = refs[1];
    assign chop        = chop_q;
    assign sample_strb = sample_tick;

    // R9
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!dec_valid && !chop));
endmodule

// File: tb/pdsd_controller_test.sv
// Scoreboard bench: the driver feeds one comparator bit per sample and
// queues the expected window count; the monitor pops on each valid pulse.
module pdsd_controller_test;
    localparam int P    = 16;
    localparam int DPS  = 2;
    localparam int NOM  = 4;
    localparam int OFF  = 2;
    localparam int CH   = 2;
    localparam int WC   = 2;
    localparam int CW   = 4;
    localparam int WIN  = 2 * CH * WC;
    localparam int NWIN = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic comp_in = 1'b0;
    logic heater_drv, ref_early, ref_late, demod_ref, chop, sample_strb, dec_valid;
    logic [CW-1:0] dec_word;

    int checks = 0;
    int fails = 0;
    int pops = 0;
    int cyc = 0;
    int exp_q[$];

    always #10 clk = ~clk;

    pdsd_controller #(
        .DRIVE_PERIOD(P), .DRIVES_PER_SAMPLE(DPS), .PHASE_NOM(NOM), .PHASE_OFF(OFF),
        .CHOP_HALF(CH), .WINDOW_CHOPS(WC), .CNT_W(CW)
    ) uut (
        .clk(clk), .rst_n(rst_n), .comp_in(comp_in), .heater_drv(heater_drv),
        .ref_early(ref_early), .ref_late(ref_late), .demod_ref(demod_ref),
        .chop(chop), .sample_strb(sample_strb), .dec_word(dec_word), .dec_valid(dec_valid)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cyc);
        end
    endtask

    function automatic bit chop_exp(input int k);
        return ((k / CH) % 2) == 1;
    endfunction

    function automatic bit pat_bit(input int pat, input int i, input int k);
        case (pat)
            0: return 1'b1;
            1: return chop_exp(k);
            2: return !chop_exp(k);
            default: return (i % 3) == 0;
        endcase
    endfunction

    // Driver: one window of a pattern, pushes the expected count (R6, R7, R8).
    int k_glob = 0;
    task automatic run_window(input int pat);
        int exp_cnt = 0;
        for (int i = 0; i < WIN; i++) begin
            bit b;
            @(negedge clk);
            if (k_glob > 0)  // R5: drive count 0, heater is inverted drive
                check(heater_drv == !chop_exp(k_glob), "R5 heater", heater_drv, !chop_exp(k_glob));
            b = pat_bit(pat, i, k_glob);
            comp_in = b;
            exp_cnt += int'(b ^ chop_exp(k_glob));
            while (!sample_strb) @(negedge clk);
            check(chop == chop_exp(k_glob), "R5 chop", chop, chop_exp(k_glob));
            k_glob++;
            @(posedge clk);
        end
        exp_q.push_back(exp_cnt);
    endtask

    // Monitor: demod selection (R4), strobe spacing (R3), window results (R7).
    bit exp_sel = 1'b0;
    int last_strb = -1;
    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            check(demod_ref == (exp_sel ? ref_late : ref_early), "R4 demod",
                  demod_ref, exp_sel ? ref_late : ref_early);
            if (sample_strb) begin
                if (last_strb >= 0)
                    check(cyc - last_strb == P * DPS, "R3 strobe", cyc - last_strb, P * DPS);
                last_strb = cyc;
                exp_sel = comp_in;
            end
            if (dec_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R7 unexpected valid", int'(dec_word), -1);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    pops++;
                    check(int'(dec_word) == e, "R7 R8 count", int'(dec_word), e);
                end
            end
        end
    end

    // Phase monitor: drive period (R1) and reference offsets (R2).
    bit sq_prev = 1'b0, er_prev = 1'b0, lt_prev = 1'b0;
    int rise_at = -1;
    int nphase = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            bit sq;
            sq = heater_drv ^ chop;
            if (sq && !sq_prev) begin
                if (rise_at >= 0 && nphase < 20)
                    check(cyc - rise_at == P, "R1 period", cyc - rise_at, P);
                rise_at = cyc;
                nphase++;
            end
            if (rise_at >= 0 && nphase < 20) begin
                if (ref_early && !er_prev)
                    check(cyc - rise_at == NOM - OFF, "R2 early", cyc - rise_at, NOM - OFF);
                if (ref_late && !lt_prev)
                    check(cyc - rise_at == NOM + OFF, "R2 late", cyc - rise_at, NOM + OFF);
            end
            sq_prev = sq;
            er_prev = ref_early;
            lt_prev = ref_late;
        end
    end

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    // Main sequence.
    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R9 reset state
        check(dec_valid == 1'b0, "R9 valid", dec_valid, 0);
        check(dec_word == '0, "R9 word", int'(dec_word), 0);
        check(chop == 1'b0, "R9 chop", chop, 0);
        check(demod_ref == ref_early, "R9 demod", demod_ref, ref_early);
        rst_n = 1'b1;
        for (int w = 0; w < NWIN; w++) run_window(w);
        repeat (4) @(negedge clk);
        check(pops == NWIN, "R7 windows", pops, NWIN);
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule